// File: doc/BRIEF.md
# Security Bit Access Controller

This block sits between a programming engine and the configuration storage of a programmable logic device. It takes one command at a time over a valid/ready request channel. A command can read or write an array word, preload the output registers, lock the device, bulk-erase it, or read or write a user signature byte. The block holds a sticky security bit and an eight-byte user signature. It checks each command against the security bit. Allowed array accesses, preloads and erases go out to the storage as single-cycle strobes. Every accepted command gets exactly one response, carrying a status code and read data.

Once the security bit is set, array verify reads and register preloads are refused. A refused command has no side effects. The signature stays readable and writable whether or not the device is locked. The lock applies to the very next command, so locking is meant to be the last programming step. Only a bulk erase removes the lock. A bulk erase also wipes the array, and it wipes the signature only when its signature-clear flag is set.

Back-pressure rules: a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever no response is pending or the pending response is being taken on that same edge. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new command is taken. The configuration storage must return `arr_rdata` within the same cycle as the address it is given.

Top module: `sac_access_ctrl`

## Requirements
- R1: After reset the security bit is clear, `rsp_valid` is 0, `cmd_ready` is 1 and all signature bytes read as 0.
- R2: An accepted command produces `rsp_valid` on the next cycle. `cmd_ready` equals `!rsp_valid || rsp_ready`. While the response is stalled, `rsp_status` and `rsp_data` hold stable.
- R3: Opcode 0 (array read) on an unlocked device pulses `arr_en` with `arr_we`=0 in the accept cycle. It returns the stored word with status 0 (OK).
- R4: Opcode 1 (array write) is forwarded in both lock states, as `arr_en`=1, `arr_we`=1 with the address and data, and returns status 0 with data 0.
- R5: Opcode 3 (lock) sets the security bit, visible on `secured` one cycle after acceptance, and the command accepted right after already sees it.
- R6: An array read on a locked device returns status 1 (protection error) and data 0, and does not raise `arr_en`.
- R7: Opcode 2 (preload) pulses `pre_en` with `pre_data` = write data when unlocked. When locked it returns status 1 and data 0, and `pre_en` stays low.
- R8: Opcodes 5 (signature read) and 6 (signature write) reach byte `cmd_addr[2:0]` in both lock states with status 0. A read returns the byte zero-extended, and a write returns data 0.
- R9: Opcode 4 (bulk erase) clears the security bit and pulses `arr_erase`. The signature keeps its contents unless `cmd_sig_clr` is 1, in which case every byte becomes 0.
- R10: Opcode 7 is reserved. It returns status 2 (bad command) and data 0, and changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Array address; low 3 bits select the signature byte |
| cmd_wdata | input | DATA_W | Write or preload data |
| cmd_sig_clr | input | 1 | Bulk erase also clears the signature |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 0 OK, 1 protection error, 2 bad command |
| rsp_data | output | DATA_W | Read data, zero when not a read or when refused |
| arr_en | output | 1 | Array access strobe |
| arr_we | output | 1 | Array access is a write |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data, same cycle |
| arr_erase | output | 1 | Whole-array erase strobe |
| pre_en | output | 1 | Register preload strobe |
| pre_data | output | DATA_W | Preload value |
| secured | output | 1 | Security bit |

## Verification
The hardest situation to reach is a lock followed by a command in the very next cycle, while a response is also stalled. The stimulus issues lock and array-read back to back, with no idle cycle between them. It also inserts random response stalls into a long random command stream, where locks and erases interleave with refused reads and preloads. A bench model of the lock bit, the signature and the array predicts every strobe and response.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [2:0] {
    OP_ARD   = 3'd0,
    OP_AWR   = 3'd1,
    OP_PRE   = 3'd2,
    OP_LOCK  = 3'd3,
    OP_ERASE = 3'd4,
    OP_SRD   = 3'd5,
    OP_SWR   = 3'd6,
    OP_RSVD  = 3'd7
  } sac_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PROT  = 2'd1,
    ST_BADOP = 2'd2
  } sac_st_e;

  typedef struct packed {
    sac_st_e st;
    logic    arr_rd;
    logic    arr_wr;
    logic    pre;
    logic    lock;
    logic    erase;
    logic    sig_rd;
    logic    sig_wr;
  } sac_grant_t;
endpackage

// File: rtl/sac_guard.sv
module sac_guard
  import sac_pkg::*;
(
  input  sac_op_e    op_i,
  input  logic       secured_i,
  output sac_grant_t grant_o
);
  always_comb begin
    grant_o    = '0;
    grant_o.st = ST_OK;
    unique case (op_i)
      OP_ARD:   if (secured_i) grant_o.st = ST_PROT; else grant_o.arr_rd = 1'b1;
      OP_AWR:   grant_o.arr_wr = 1'b1;
      OP_PRE:   if (secured_i) grant_o.st = ST_PROT; else grant_o.pre = 1'b1;
      OP_LOCK:  grant_o.lock = 1'b1;
      OP_ERASE: grant_o.erase = 1'b1;
      OP_SRD:   grant_o.sig_rd = 1'b1;
      OP_SWR:   grant_o.sig_wr = 1'b1;
      default:  grant_o.st = ST_BADOP;
    endcase
  end
endmodule

// File: rtl/sac_lock.sv
module sac_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic secured_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     secured_o <= 1'b0;
    else if (clr_i) secured_o <= 1'b0;
    else if (set_i) secured_o <= 1'b1;
  end

  // R5 and R9: the bit is sticky until an erase
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    secured_o && !clr_i |=> secured_o);
  a_r5_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> secured_o);
  a_r9_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !secured_o);
endmodule

// File: rtl/sac_sig_bank.sv
module sac_sig_bank #(
  parameter int BYTES = 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o
);
  logic [7:0] bytes_q [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bytes_q[i] <= '0;
      else if (clr_i)                              bytes_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))   bytes_q[i] <= wr_data_i;
    end

    // R9: a clearing erase empties every byte
    a_r9_sig_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> bytes_q[i] == 8'h00);
    // R8: bytes not addressed keep their value
    a_r8_sig_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i && !(wr_en_i && wr_idx_i == IDX_W'(i)) |=> $stable(bytes_q[i]));
  end

  assign rd_data_o = bytes_q[rd_idx_i];
endmodule

// File: rtl/sac_access_ctrl.sv
module sac_access_ctrl
  import sac_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SIG_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_sig_clr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_data,
  output logic              arr_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_erase,
  output logic              pre_en,
  output logic [DATA_W-1:0] pre_data,
  output logic              secured
);
  localparam int SIG_IDX_W = $clog2(SIG_BYTES);

  logic              accept;
  sac_grant_t        grant;
  logic [7:0]        sig_rd;
  logic [DATA_W-1:0] rd_mux;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;

  sac_guard u_guard (
    .op_i      (sac_op_e'(cmd_op)),
    .secured_i (secured),
    .grant_o   (grant)
  );

  sac_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (accept && grant.lock),
    .clr_i     (accept && grant.erase),
    .secured_o (secured)
  );

  sac_sig_bank #(.BYTES(SIG_BYTES)) u_sig (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (accept && grant.sig_wr),
    .wr_idx_i  (cmd_addr[SIG_IDX_W-1:0]),
    .wr_data_i (cmd_wdata[7:0]),
    .clr_i     (accept && grant.erase && cmd_sig_clr),
    .rd_idx_i  (cmd_addr[SIG_IDX_W-1:0]),
    .rd_data_o (sig_rd)
  );

  assign arr_en    = accept && (grant.arr_rd || grant.arr_wr);
  assign arr_we    = accept && grant.arr_wr;
  assign arr_addr  = cmd_addr;
  assign arr_wdata = cmd_wdata;
  assign arr_erase = accept && grant.erase;
  assign pre_en    = accept && grant.pre;
  assign pre_data  = cmd_wdata;

  always_comb begin
    rd_mux = '0;
    if (grant.arr_rd)      rd_mux = arr_rdata;
    else if (grant.sig_rd) rd_mux = DATA_W'(sig_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_data   <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_status <= grant.st;
      rsp_data   <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  // R2: response timing and stall behaviour
  a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));
  // R6: no verify read reaches the array while locked
  a_r6_no_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    arr_en && !arr_we |-> !secured);
  // R7: no preload while locked
  a_r7_no_locked_preload: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |-> !secured);
  // R6 and R10: refused or unknown commands return zero data
  a_r6_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != 2'd0 |-> rsp_data == '0);
  // R2: at most one strobe per accepted command
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_en, arr_erase, pre_en}));
endmodule

// File: tb/tb_sac_access_ctrl.sv
module tb_sac_access_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_sig_clr = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_data;
  logic          arr_en, arr_we, arr_erase, pre_en, secured;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, arr_rdata, pre_data;

  always #4 clk = ~clk;

  sac_access_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_sig_clr(cmd_sig_clr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .arr_en(arr_en),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .arr_erase(arr_erase), .pre_en(pre_en),
    .pre_data(pre_data), .secured(secured)
  );

  // configuration storage: asynchronous read, write and erase on the edge
  logic [DW-1:0] mem [1<<AW];
  assign arr_rdata = mem[arr_addr];
  always_ff @(posedge clk) begin
    if (arr_erase) for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
    else if (arr_en && arr_we) mem[arr_addr] <= arr_wdata;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bit         m_sec = 0;
  logic [7:0] m_sig [8];
  bit         pend = 0;
  logic [1:0] pend_st;
  logic [DW-1:0] pend_data;
  string      pend_req;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input bit sec);
    case (op)
      3'd0: return sec ? "R6" : "R3";
      3'd1: return "R4";
      3'd2: return "R7";
      3'd3: return "R5";
      3'd4: return "R9";
      3'd5, 3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check_pending();
    if (pend) begin
      chk(rsp_valid == 1'b1, "R2", "rsp_valid after accept", int'(rsp_valid), 1);
      chk(rsp_status == pend_st, pend_req, "rsp_status", int'(rsp_status), int'(pend_st));
      chk(rsp_data == pend_data, pend_req, "rsp_data", int'(rsp_data), int'(pend_data));
    end else begin
      chk(rsp_valid == 1'b0, "R2", "idle rsp_valid", int'(rsp_valid), 0);
    end
    chk(secured == m_sec, "R5", "secured flag", int'(secured), int'(m_sec));
  endtask

  // one negedge: check the outstanding response, then offer a command or idle
  task automatic step(input bit has, input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit se);
    string req;
    bit e_arr, e_we, e_pre, e_ers;
    @(negedge clk);
    #1;
    check_pending();
    pend = 0;
    cmd_valid = has; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_sig_clr = se;
    if (!has) return;
    #1;
    req = req_of(op, m_sec);
    e_arr = 0; e_we = 0; e_pre = 0; e_ers = 0;
    pend_st = 2'd0; pend_data = '0; pend_req = req;
    case (op)
      3'd0: if (m_sec) pend_st = 2'd1; else begin e_arr = 1; pend_data = mem[a]; end
      3'd1: begin e_arr = 1; e_we = 1; end
      3'd2: if (m_sec) pend_st = 2'd1; else e_pre = 1;
      3'd3: m_sec = 1;
      3'd4: begin
        e_ers = 1; m_sec = 0;
        if (se) for (int i = 0; i < 8; i++) m_sig[i] = 8'h00;
      end
      3'd5: pend_data = DW'(m_sig[a[2:0]]);
      3'd6: m_sig[a[2:0]] = d[7:0];
      default: pend_st = 2'd2;
    endcase
    chk(cmd_ready == 1'b1, "R2", "cmd_ready", int'(cmd_ready), 1);
    chk(arr_en == e_arr, req, "arr_en", int'(arr_en), int'(e_arr));
    chk(arr_we == e_we, req, "arr_we", int'(arr_we), int'(e_we));
    chk(pre_en == e_pre, req, "pre_en", int'(pre_en), int'(e_pre));
    chk(arr_erase == e_ers, req, "arr_erase", int'(arr_erase), int'(e_ers));
    if (e_pre) chk(pre_data == d, "R7", "pre_data", int'(pre_data), int'(d));
    if (e_arr) chk(arr_addr == a, req, "arr_addr", int'(arr_addr), int'(a));
    pend = 1;
  endtask

  // stall the pending response for n cycles
  task automatic stall(input int n);
    logic [DW-1:0] d0;
    logic [1:0] s0;
    @(negedge clk);
    cmd_valid = 0;
    rsp_ready = 0;
    #1;
    check_pending();
    d0 = rsp_data; s0 = rsp_status;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      chk(rsp_valid == 1'b1, "R2", "stalled rsp_valid", int'(rsp_valid), 1);
      chk(cmd_ready == 1'b0, "R2", "stalled cmd_ready", int'(cmd_ready), 0);
      chk(rsp_data == d0 && rsp_status == s0, "R2", "stalled rsp stable",
          int'({rsp_status, rsp_data}), int'({s0, d0}));
    end
    rsp_ready = 1;
    pend = 0;
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) m_sig[i] = 8'h00;
    void'($urandom(32'd7319));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(rsp_valid == 0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
    chk(cmd_ready == 1, "R1", "reset cmd_ready", int'(cmd_ready), 1);
    chk(secured == 0, "R1", "reset secured", int'(secured), 0);
    step(1, 3'd5, 6'd3, 8'h00, 0);          // R1 signature reads zero
    step(1, 3'd1, 6'd5, 8'hA5, 0);          // R4
    step(1, 3'd0, 6'd5, 8'h00, 0);          // R3
    step(1, 3'd2, 6'd0, 8'h5A, 0);          // R7 unlocked
    step(1, 3'd6, 6'd2, 8'h3C, 0);          // R8
    step(1, 3'd5, 6'd2, 8'h00, 0);
    step(1, 3'd7, 6'd9, 8'hFF, 1);          // R10
    step(1, 3'd0, 6'd5, 8'h00, 0);
    stall(3);                               // R2
    step(1, 3'd3, 6'd0, 8'h00, 0);          // R5 lock
    step(1, 3'd0, 6'd5, 8'h00, 0);          // R6 back to back
    step(1, 3'd2, 6'd0, 8'h77, 0);          // R7 refused
    step(1, 3'd5, 6'd2, 8'h00, 0);          // R8 locked
    step(1, 3'd6, 6'd7, 8'hC3, 0);
    step(1, 3'd5, 6'd7, 8'h00, 0);
    step(1, 3'd1, 6'd6, 8'h11, 0);          // R4 locked
    step(1, 3'd4, 6'd0, 8'h00, 0);          // R9 erase keeps signature
    step(1, 3'd5, 6'd2, 8'h00, 0);
    step(1, 3'd0, 6'd5, 8'h00, 0);
    step(1, 3'd3, 6'd0, 8'h00, 0);
    step(1, 3'd4, 6'd0, 8'h00, 1);          // R9 erase clears signature
    step(1, 3'd5, 6'd7, 8'h00, 0);
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      if ((op == 3'd3 || op == 3'd4) && ($urandom % 3 != 0)) op = 3'd0;
      step(($urandom % 5) != 0, op, 6'($urandom), 8'($urandom), ($urandom % 2) == 1);
      if (pend && ($urandom % 8 == 0)) stall(1 + int'($urandom % 3));
    end
    step(0, 3'd0, '0, '0, 0);
    step(0, 3'd0, '0, '0, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule